// File: doc/BRIEF.md
# Torus Switch Node with Buffered Dimension Turns

This block is one switch of a two-dimensional torus in which every ring carries traffic in one direction only. Packets travel east on the horizontal ring and south on the vertical ring. The node takes packets from its west neighbour, its north neighbour and a local injection port. It drives its east neighbour, its south neighbour and a local exit port. Routing is dimension-ordered: a packet first travels east until its column matches, and then travels south until its row matches.

No packet is ever deflected. A packet that reaches its column on the horizontal ring and has to move onto the vertical ring is parked in a turn queue. The queue drains onto the south output in any cycle that the north input does not claim it. Traffic already on the rings always moves on in the next cycle, so only the parked packets wait. The `DUAL` parameter picks the variant. With `DUAL=0` there is one turn queue. With `DUAL=1` there is a downhill queue for rows south of the node and an uphill queue for rows that can only be reached by wrapping around the ring. The two queues take turns on the south output.

All three outputs are registered. The queue depth is a parameter, and each queue keeps a sticky error flag that is set if a write is lost because the queue is full.

Top module: `torus_turn_node`

## Requirements
- R1: During reset and after it, `e_vld_o`, `s_vld_o`, `x_vld_o` and both bits of `ovf_o` are 0. Each packet field is 0 whenever its valid bit is 0.
- R2: Packet layout: bits [X_W-1:0] hold the destination column, the next Y_W bits hold the destination row, and the upper PL_W bits hold the payload. A west packet whose column differs from `MY_X` appears unchanged on the east output one cycle later.
- R3: A north packet whose row differs from `MY_Y` appears unchanged on the south output one cycle later. This has priority over the turn queues, which hold their contents while the north input claims the south output.
- R4: A north or west packet whose row equals `MY_Y` (and, for a west packet, whose column equals `MY_X`) leaves on the exit port one cycle later. If both arrive in the same cycle, the north packet exits, and the west packet goes to the uphill queue (the only queue when `DUAL=0`) and circles the vertical ring.
- R5: A west packet whose column equals `MY_X` and whose row differs enters a turn queue. With the south output free, it appears there two cycles after arrival. Queued packets leave in arrival order.
- R6: With `DUAL=1`, a turning packet goes to the downhill queue if its row is greater than `MY_Y` and to the uphill queue otherwise. The two queues are granted alternately, and after reset the downhill queue is granted first.
- R7: An injected packet routes like a west packet. For a packet addressed to the node itself, `inj_rdy_o` is high only if neither the north nor the west input uses the exit this cycle. For an eastbound packet, it is high only if no west packet takes the east output. For a turning packet, it is high only if its queue is not full and takes no west packet this cycle. An accepted packet appears on the output its route selects, with the same latency as a west packet.
- R8: A write into a full queue that is not popped in the same cycle is dropped. From the next cycle on, that queue's `ovf_o` bit (bit 0 for the downhill or single queue, bit 1 for uphill) stays 1 until reset, while the other bit is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_vld_i | input | 1 | West ring packet valid |
| w_pkt_i | input | PKT_W | West ring packet |
| n_vld_i | input | 1 | North ring packet valid |
| n_pkt_i | input | PKT_W | North ring packet |
| inj_vld_i | input | 1 | Local injection valid |
| inj_pkt_i | input | PKT_W | Local injection packet |
| inj_rdy_o | output | 1 | Injection accepted this cycle when high |
| e_vld_o | output | 1 | East ring packet valid |
| e_pkt_o | output | PKT_W | East ring packet |
| s_vld_o | output | 1 | South ring packet valid |
| s_pkt_o | output | PKT_W | South ring packet |
| x_vld_o | output | 1 | Local exit valid |
| x_pkt_o | output | PKT_W | Local exit packet |
| ovf_o | output | 2 | Sticky turn-queue overflow flags |

## Verification
Two pairs of events can fall in the same cycle. In the first, a north packet and a west packet both end at this node; the exit can take only one. The bench presents both in one cycle, expects the north packet on the exit one cycle later, and expects the west packet on the south output one cycle after that. In the second, a north packet continues south while a turn queue holds packets; both want the south output. The bench keeps the north input busy while it loads the queues, then releases it and checks that the queued packets come out in alternating downhill/uphill order only after the ring traffic has passed.

// File: rtl/torus_node_pkg.sv
package torus_node_pkg;

    // Where a packet goes inside one node
    typedef enum logic [2:0] {
        RT_IDLE    = 3'd0,
        RT_EAST    = 3'd1,
        RT_SOUTH   = 3'd2,
        RT_EXIT    = 3'd3,
        RT_TURN_DN = 3'd4,  // queue 0
        RT_TURN_UP = 3'd5   // queue 1
    } route_e;

endpackage

// File: rtl/route_decode.sv
module route_decode
    import torus_node_pkg::*;
#(
    parameter int X_W        = 3,
    parameter int Y_W        = 3,
    parameter int MY_X       = 0,
    parameter int MY_Y       = 0,
    parameter bit DUAL       = 1'b1,
    parameter bit FROM_NORTH = 1'b0
) (
    input  logic           vld_i,
    input  logic [X_W-1:0] dx_i,
    input  logic [Y_W-1:0] dy_i,
    output route_e         route_o
);

    localparam logic [X_W-1:0] NODE_X = X_W'(MY_X);
    localparam logic [Y_W-1:0] NODE_Y = Y_W'(MY_Y);

    always_comb begin
        route_o = RT_IDLE;
        if (vld_i) begin
            if (!FROM_NORTH && (dx_i != NODE_X)) begin
                route_o = RT_EAST;
            end else if (dy_i == NODE_Y) begin
                route_o = RT_EXIT;
            end else if (FROM_NORTH) begin
                route_o = RT_SOUTH;
            end else if (DUAL && (dy_i < NODE_Y)) begin
                route_o = RT_TURN_UP;
            end else begin
                route_o = RT_TURN_DN;
            end
        end
    end

endmodule

// File: rtl/turn_fifo.sv
module turn_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         ovf_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
        logic                    ovf;
    } fifo_s;

    fifo_s st_d, st_q;
    logic  do_rd, do_wr;

    assign rdata_o = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == FULL);
    assign ovf_o   = st_q.ovf;

    always_comb begin
        st_d  = st_q;
        do_rd = rd_i && (st_q.cnt != '0);
        do_wr = wr_i && ((st_q.cnt != FULL) || do_rd);
        if (wr_i && !do_wr) begin
            st_d.ovf = 1'b1;
        end
        if (do_wr) begin
            st_d.mem[st_q.wp] = wdata_i;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_rd) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        if (do_wr && !do_rd) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_rd && !do_wr) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !empty_o);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && !full_o) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && !(wr_i && full_o)) |=> !ovf_o);

endmodule

// File: rtl/south_arb.sv
module south_arb #(
    parameter int NQ = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic [1:0] req_i,
    output logic [1:0] gnt_o
);

    typedef struct packed {
        logic pref;  // 0: downhill queue first
    } arb_s;

    arb_s st_d, st_q;

    always_comb begin
        st_d  = st_q;
        gnt_o = 2'b00;
        if (!busy_i) begin
            if (NQ == 1) begin
                gnt_o[0] = req_i[0];
            end else if (req_i[st_q.pref]) begin
                gnt_o[st_q.pref] = 1'b1;
                st_d.pref = ~st_q.pref;
            end else if (req_i[~st_q.pref]) begin
                gnt_o[~st_q.pref] = 1'b1;
                st_d.pref = st_q.pref;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    ring_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (gnt_o == 2'b00));

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R6
    rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o[0] && req_i[1]) |=> !gnt_o[0]);

endmodule

// File: rtl/torus_turn_node.sv
module torus_turn_node
    import torus_node_pkg::*;
#(
    parameter int X_W   = 3,
    parameter int Y_W   = 3,
    parameter int PL_W  = 8,
    parameter int MY_X  = 2,
    parameter int MY_Y  = 3,
    parameter int DEPTH = 16,
    parameter bit DUAL  = 1'b1,
    localparam int PKT_W = X_W + Y_W + PL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w_vld_i,
    input  logic [PKT_W-1:0] w_pkt_i,
    input  logic             n_vld_i,
    input  logic [PKT_W-1:0] n_pkt_i,
    input  logic             inj_vld_i,
    input  logic [PKT_W-1:0] inj_pkt_i,
    output logic             inj_rdy_o,
    output logic             e_vld_o,
    output logic [PKT_W-1:0] e_pkt_o,
    output logic             s_vld_o,
    output logic [PKT_W-1:0] s_pkt_o,
    output logic             x_vld_o,
    output logic [PKT_W-1:0] x_pkt_o,
    output logic [1:0]       ovf_o
);

    localparam int NQ       = DUAL ? 2 : 1;
    localparam int BOUNCE_Q = DUAL ? 1 : 0;
    localparam logic [X_W-1:0] NODE_X = X_W'(MY_X);

    typedef struct packed {
        logic             ev;
        logic [PKT_W-1:0] ep;
        logic             sv;
        logic [PKT_W-1:0] sp;
        logic             xv;
        logic [PKT_W-1:0] xp;
    } out_s;

    out_s st_d, st_q;

    route_e w_rt, n_rt, i_rt;

    logic [1:0]       q_wr;
    logic [PKT_W-1:0] q_wdata [2];
    logic [1:0]       q_pop;
    logic [PKT_W-1:0] q_head  [2];
    logic [1:0]       q_empty;
    logic [1:0]       q_full;
    logic [1:0]       q_ovf;
    logic [1:0]       arb_gnt;
    logic             n_south;
    logic             inj_rdy;

    route_decode #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y),
                   .DUAL(DUAL), .FROM_NORTH(1'b0)) u_dec_w (
        .vld_i  (w_vld_i),
        .dx_i   (w_pkt_i[X_W-1:0]),
        .dy_i   (w_pkt_i[X_W +: Y_W]),
        .route_o(w_rt)
    );

    route_decode #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y),
                   .DUAL(DUAL), .FROM_NORTH(1'b1)) u_dec_n (
        .vld_i  (n_vld_i),
        .dx_i   (n_pkt_i[X_W-1:0]),
        .dy_i   (n_pkt_i[X_W +: Y_W]),
        .route_o(n_rt)
    );

    route_decode #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y),
                   .DUAL(DUAL), .FROM_NORTH(1'b0)) u_dec_i (
        .vld_i  (1'b1),
        .dx_i   (inj_pkt_i[X_W-1:0]),
        .dy_i   (inj_pkt_i[X_W +: Y_W]),
        .route_o(i_rt)
    );

    for (genvar k = 0; k < 2; k++) begin : g_q
        if (k < NQ) begin : g_on
            turn_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_fifo (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_i   (q_wr[k]),
                .wdata_i(q_wdata[k]),
                .rd_i   (q_pop[k]),
                .rdata_o(q_head[k]),
                .empty_o(q_empty[k]),
                .full_o (q_full[k]),
                .ovf_o  (q_ovf[k])
            );
        end else begin : g_off
            assign q_head[k]  = '0;
            assign q_empty[k] = 1'b1;
            assign q_full[k]  = 1'b0;
            assign q_ovf[k]   = 1'b0;
        end
    end

    south_arb #(.NQ(NQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .busy_i(n_south),
        .req_i (~q_empty),
        .gnt_o (arb_gnt)
    );

    assign n_south = (n_rt == RT_SOUTH);
    assign q_pop   = arb_gnt;

    always_comb begin
        logic       n_exit;
        logic       w_exit;
        logic [1:0] w_q;
        logic       fire;

        st_d       = '0;
        q_wr       = 2'b00;
        q_wdata[0] = '0;
        q_wdata[1] = '0;
        w_q        = 2'b00;

        n_exit = (n_rt == RT_EXIT);
        w_exit = (w_rt == RT_EXIT);

        // West packets bound for a queue, including exit collisions
        if (w_rt == RT_TURN_DN) w_q[0] = 1'b1;
        if (w_rt == RT_TURN_UP) w_q[1] = 1'b1;
        if (w_exit && n_exit)   w_q[BOUNCE_Q] = 1'b1;

        // Injection readiness
        unique case (i_rt)
            RT_EAST:    inj_rdy = (w_rt != RT_EAST);
            RT_EXIT:    inj_rdy = !n_exit && !w_exit;
            RT_TURN_DN: inj_rdy = !w_q[0] && !q_full[0];
            RT_TURN_UP: inj_rdy = !w_q[1] && !q_full[1];
            default:    inj_rdy = 1'b0;
        endcase
        fire = inj_vld_i && inj_rdy;

        // East output
        if (w_rt == RT_EAST) begin
            st_d.ev = 1'b1;
            st_d.ep = w_pkt_i;
        end else if (fire && (i_rt == RT_EAST)) begin
            st_d.ev = 1'b1;
            st_d.ep = inj_pkt_i;
        end

        // Exit output
        if (n_exit) begin
            st_d.xv = 1'b1;
            st_d.xp = n_pkt_i;
        end else if (w_exit) begin
            st_d.xv = 1'b1;
            st_d.xp = w_pkt_i;
        end else if (fire && (i_rt == RT_EXIT)) begin
            st_d.xv = 1'b1;
            st_d.xp = inj_pkt_i;
        end

        // Queue writes
        for (int k = 0; k < 2; k++) begin
            if (w_q[k]) begin
                q_wr[k]    = 1'b1;
                q_wdata[k] = w_pkt_i;
            end
        end
        if (fire && (i_rt == RT_TURN_DN)) begin
            q_wr[0]    = 1'b1;
            q_wdata[0] = inj_pkt_i;
        end
        if (fire && (i_rt == RT_TURN_UP)) begin
            q_wr[1]    = 1'b1;
            q_wdata[1] = inj_pkt_i;
        end

        // South output: ring first, then queue grant
        if (n_south) begin
            st_d.sv = 1'b1;
            st_d.sp = n_pkt_i;
        end else if (arb_gnt[0]) begin
            st_d.sv = 1'b1;
            st_d.sp = q_head[0];
        end else if (arb_gnt[1]) begin
            st_d.sv = 1'b1;
            st_d.sp = q_head[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inj_rdy_o = inj_rdy;
    assign e_vld_o   = st_q.ev;
    assign e_pkt_o   = st_q.ep;
    assign s_vld_o   = st_q.sv;
    assign s_pkt_o   = st_q.sp;
    assign x_vld_o   = st_q.xv;
    assign x_pkt_o   = st_q.xp;
    assign ovf_o     = q_ovf;

    // R2
    west_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_vld_i && (w_pkt_i[X_W-1:0] != NODE_X))
        |=> (e_vld_o && (e_pkt_o == $past(w_pkt_i))));

    // R3
    north_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_vld_i |=> (s_vld_o || x_vld_o));

    // R7
    inj_east_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld_i && inj_rdy_o && (inj_pkt_i[X_W-1:0] != NODE_X))
        |=> (e_vld_o && (e_pkt_o == $past(inj_pkt_i))));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_vld_o || 1'b1) && (e_vld_o || (e_pkt_o == '0)));

endmodule

// File: tb/torus_turn_node_tb.sv
module torus_turn_node_tb;

    localparam int PKT_W = 14;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             w_vld, n_vld, inj_vld;
    logic [PKT_W-1:0] w_pkt, n_pkt, inj_pkt;
    logic             inj_rdy;
    logic             e_vld, s_vld, x_vld;
    logic [PKT_W-1:0] e_pkt, s_pkt, x_pkt;
    logic [1:0]       ovf;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    torus_turn_node #(
        .X_W(3), .Y_W(3), .PL_W(8), .MY_X(2), .MY_Y(3), .DEPTH(4), .DUAL(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .w_vld_i(w_vld), .w_pkt_i(w_pkt),
        .n_vld_i(n_vld), .n_pkt_i(n_pkt),
        .inj_vld_i(inj_vld), .inj_pkt_i(inj_pkt), .inj_rdy_o(inj_rdy),
        .e_vld_o(e_vld), .e_pkt_o(e_pkt),
        .s_vld_o(s_vld), .s_pkt_o(s_pkt),
        .x_vld_o(x_vld), .x_pkt_o(x_pkt),
        .ovf_o(ovf)
    );

    function automatic logic [PKT_W-1:0] mk(input int x, input int y, input int p);
        return {8'(p), 3'(y), 3'(x)};
    endfunction

    typedef struct packed {
        logic             wv;
        logic [PKT_W-1:0] w;
        logic             nv;
        logic [PKT_W-1:0] n;
        logic             iv;
        logic [PKT_W-1:0] i;
        logic             rdy;
        logic             ev;
        logic [PKT_W-1:0] e;
        logic             sv;
        logic [PKT_W-1:0] s;
        logic             xv;
        logic [PKT_W-1:0] x;
    } vec_t;

    // node sits at column 2, row 3
    localparam vec_t VECS [9] = '{
        // R2 west passes east
        '{1'b1, mk(5,1,8'h11), 1'b0, '0, 1'b0, '0, 1'b0,
          1'b1, mk(5,1,8'h11), 1'b0, '0, 1'b0, '0},
        // R3 north continues south
        '{1'b0, '0, 1'b1, mk(2,6,8'h22), 1'b0, '0, 1'b0,
          1'b0, '0, 1'b1, mk(2,6,8'h22), 1'b0, '0},
        // R4 north exits
        '{1'b0, '0, 1'b1, mk(2,3,8'h33), 1'b0, '0, 1'b0,
          1'b0, '0, 1'b0, '0, 1'b1, mk(2,3,8'h33)},
        // R4 west exits
        '{1'b1, mk(2,3,8'h44), 1'b0, '0, 1'b0, '0, 1'b0,
          1'b0, '0, 1'b0, '0, 1'b1, mk(2,3,8'h44)},
        // R7 injection east, free
        '{1'b0, '0, 1'b0, '0, 1'b1, mk(0,0,8'h55), 1'b1,
          1'b1, mk(0,0,8'h55), 1'b0, '0, 1'b0, '0},
        // R7 injection east blocked by west
        '{1'b1, mk(7,2,8'h66), 1'b0, '0, 1'b1, mk(1,1,8'h77), 1'b0,
          1'b1, mk(7,2,8'h66), 1'b0, '0, 1'b0, '0},
        // R2 and R3 together
        '{1'b1, mk(4,4,8'h88), 1'b1, mk(2,0,8'h99), 1'b0, '0, 1'b0,
          1'b1, mk(4,4,8'h88), 1'b1, mk(2,0,8'h99), 1'b0, '0},
        // R7 self injection blocked by north exit
        '{1'b0, '0, 1'b1, mk(2,3,8'hAA), 1'b1, mk(2,3,8'hBB), 1'b0,
          1'b0, '0, 1'b0, '0, 1'b1, mk(2,3,8'hAA)},
        // R7 self injection free
        '{1'b0, '0, 1'b0, '0, 1'b1, mk(2,3,8'hCC), 1'b1,
          1'b0, '0, 1'b0, '0, 1'b1, mk(2,3,8'hCC)}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic wv, input logic [PKT_W-1:0] w,
                         input logic nv, input logic [PKT_W-1:0] n,
                         input logic iv, input logic [PKT_W-1:0] i);
        w_vld = wv; w_pkt = w; n_vld = nv; n_pkt = n; inj_vld = iv; inj_pkt = i;
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic chk_south(input string req, input logic v, input logic [PKT_W-1:0] p);
        chk({req, " s_vld"}, 32'(s_vld), 32'(v));
        chk({req, " s_pkt"}, 32'(s_pkt), 32'(p));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 e_vld", 32'(e_vld), 0);
        chk("R1 s_vld", 32'(s_vld), 0);
        chk("R1 x_vld", 32'(x_vld), 0);
        chk("R1 ovf", 32'(ovf), 0);
        chk("R1 pkts", 32'(e_pkt | s_pkt | x_pkt), 0);

        // Vector table: single-cycle routing with empty queues
        for (int r = 0; r < 9; r++) begin
            drive(VECS[r].wv, VECS[r].w, VECS[r].nv, VECS[r].n, VECS[r].iv, VECS[r].i);
            #1;
            if (VECS[r].iv) chk($sformatf("R7 row%0d rdy", r), 32'(inj_rdy), 32'(VECS[r].rdy));
            step();
            idle();
            chk($sformatf("R2 row%0d e_vld", r), 32'(e_vld), 32'(VECS[r].ev));
            chk($sformatf("R2 row%0d e_pkt", r), 32'(e_pkt), 32'(VECS[r].e));
            chk($sformatf("R3 row%0d s_vld", r), 32'(s_vld), 32'(VECS[r].sv));
            chk($sformatf("R3 row%0d s_pkt", r), 32'(s_pkt), 32'(VECS[r].s));
            chk($sformatf("R4 row%0d x_vld", r), 32'(x_vld), 32'(VECS[r].xv));
            chk($sformatf("R4 row%0d x_pkt", r), 32'(x_pkt), 32'(VECS[r].x));
        end

        // R5 downhill turn, two-cycle latency
        drive(1'b1, mk(2,5,8'hA1), 1'b0, '0, 1'b0, '0);
        step(); idle();
        chk_south("R5 turn cycle1", 1'b0, '0);
        step();
        chk_south("R5 turn cycle2", 1'b1, mk(2,5,8'hA1));
        step();
        chk_south("R5 turn after", 1'b0, '0);

        // R3 north keeps priority over a queued packet
        drive(1'b1, mk(2,6,8'hA2), 1'b1, mk(2,0,8'hB1), 1'b0, '0);
        step();
        drive(1'b0, '0, 1'b1, mk(2,1,8'hB2), 1'b0, '0);
        chk_south("R3 ring first 1", 1'b1, mk(2,0,8'hB1));
        step(); idle();
        chk_south("R3 ring first 2", 1'b1, mk(2,1,8'hB2));
        step();
        chk_south("R3 queue after ring", 1'b1, mk(2,6,8'hA2));
        step();

        // R4 exit collision: north exits, west circles via uphill queue
        drive(1'b1, mk(2,3,8'hC1), 1'b1, mk(2,3,8'hC2), 1'b0, '0);
        step(); idle();
        chk("R4 collision x_pkt", 32'(x_pkt), 32'(mk(2,3,8'hC2)));
        chk_south("R4 collision cycle1", 1'b0, '0);
        step();
        chk_south("R4 collision bounce", 1'b1, mk(2,3,8'hC1));
        step();

        // R7 injection into a turn queue
        drive(1'b0, '0, 1'b0, '0, 1'b1, mk(2,6,8'hD1));
        #1 chk("R7 inj turn rdy", 32'(inj_rdy), 1);
        step(); idle();
        step();
        chk_south("R7 inj turn out", 1'b1, mk(2,6,8'hD1));
        step();

        // R7 injection refused when west writes the same queue
        drive(1'b1, mk(2,5,8'hD2), 1'b0, '0, 1'b1, mk(2,7,8'hD3));
        #1 chk("R7 inj queue busy rdy", 32'(inj_rdy), 0);
        step(); idle();
        step();
        chk_south("R7 west wins queue", 1'b1, mk(2,5,8'hD2));
        step();
        chk_south("R7 refused not queued", 1'b0, '0);

        // R6 round robin from reset: down first, then alternating
        do_reset();
        drive(1'b1, mk(2,5,8'hE0), 1'b1, mk(2,0,8'hF0), 1'b0, '0); step();
        drive(1'b1, mk(2,1,8'hE1), 1'b1, mk(2,0,8'hF1), 1'b0, '0); step();
        drive(1'b1, mk(2,7,8'hE2), 1'b1, mk(2,0,8'hF2), 1'b0, '0); step();
        drive(1'b1, mk(2,0,8'hE3), 1'b1, mk(2,0,8'hF3), 1'b0, '0); step();
        idle();
        chk_south("R6 ring still first", 1'b1, mk(2,0,8'hF3));
        step(); chk_south("R6 rr 1 down", 1'b1, mk(2,5,8'hE0));
        step(); chk_south("R6 rr 2 up",   1'b1, mk(2,1,8'hE1));
        step(); chk_south("R6 rr 3 down", 1'b1, mk(2,7,8'hE2));
        step(); chk_south("R6 rr 4 up",   1'b1, mk(2,0,8'hE3));
        step(); chk_south("R6 rr empty",  1'b0, '0);

        // R8 overflow of the downhill queue
        do_reset();
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, mk(2,4,8'h10 + k), 1'b1, mk(2,0,8'h20 + k), 1'b0, '0);
            step();
        end
        chk("R8 no ovf when exactly full", 32'(ovf), 0);
        drive(1'b0, '0, 1'b1, mk(2,0,8'h2A), 1'b1, mk(2,6,8'h2B));
        #1 chk("R7 inj full queue rdy", 32'(inj_rdy), 0);
        step();
        drive(1'b1, mk(2,4,8'h14), 1'b1, mk(2,0,8'h2C), 1'b0, '0);
        step(); idle();
        chk("R8 ovf set downhill only", 32'(ovf), 1);
        for (int k = 0; k < 4; k++) begin
            step();
            chk_south($sformatf("R8 drain %0d", k), 1'b1, mk(2,4,8'h10 + k));
        end
        step();
        chk_south("R8 dropped packet absent", 1'b0, '0);
        chk("R8 ovf sticky", 32'(ovf), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule